// File: doc/BRIEF.md
# Word-Granular Memory-to-Memory Copy Engine

The engine copies a block of 16-bit words from a 20-bit source address to a 16-bit destination address. It handles one word at a time as byte traffic. The processor programs it through byte-wide I/O ports. There are three source lanes, two destination lanes, two lanes for the byte count and one control lane. Writing the control lane with its start bit set launches the copy on the next clock edge. A busy output then holds the processor in wait until the copy is done.

After a fixed preparation period the engine alternates two-cycle word slots. In each slot it reads the low byte and then the high byte of one source word, and it writes the word fetched in the previous slot, low byte then high byte. Both addresses move by two per word, either upward or downward, and wrap within their own width. The count also drops by two per word. Two conditions cancel the start request and copy nothing: a count of zero, and a source whose top four address bits equal 1, which selects the battery-backed bank. When a copy finishes, the registers hold the advanced addresses and a zero count.

Top module: `dma_word_engine`

## Requirements
- R1: Byte lanes decode at I/O addresses 0x40/0x41/0x42 (source bits 7:0, 15:8, 19:16), 0x44/0x45 (destination bits 7:0, 15:8), 0x46/0x47 (count bits 7:0, 15:8). Bit 0 of the source, destination and count is always stored as 0. Only data bits 3:0 are kept at 0x42, and a read of 0x42 returns them with bits 7:4 as zero.
- R2: Address 0x48 is control. Bit 7 is the run flag and bit 0 is the direction (0 up, 1 down). A read returns the run flag in bit 7, the direction in bit 0 and zeros in bits 6:1. A read of any other address returns 0.
- R3: A control write with bit 7 set, a nonzero count and a source bank other than 1 raises busy on the next clock edge. Busy never rises without such a write.
- R4: A start request with a count of zero copies nothing, never raises busy, and leaves the run flag reading 0.
- R5: A start request whose source bits 19:16 equal 1 copies nothing, never raises busy, and leaves the run flag reading 0.
- R6: A copy of N words keeps busy high for exactly 5 + 2N clock cycles.
- R7: For each word, the low-byte read (even address) comes first and is followed on the next cycle by the high-byte read (odd address). The low-byte write follows both reads, and the high-byte write comes one cycle after it. The first read happens 3 cycles after busy rises.
- R8: Counting upward, destination byte d+2k (+1) receives source byte s+2k (+1) for every word k.
- R9: Counting downward, destination byte d-2k (+1) receives source byte s-2k (+1) for every word k.
- R10: When a copy ends, the run flag reads 0 and the count reads 0. The source and destination read as their starting values moved by 2N in the chosen direction.
- R11: Source stepping wraps modulo 2^20 and destination stepping wraps modulo 2^16, in both directions.
- R12: I/O writes that arrive while busy is high change no register and do not stop the copy.
- R13: No memory read or write strobe is asserted while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O lane address |
| io_we | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr, combinational |
| busy | output | 1 | High while a copy is running; stalls the processor |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_raddr | output | 20 | Memory read byte address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_raddr |
| mem_wr | output | 1 | Memory byte write strobe |
| mem_waddr | output | 20 | Memory write byte address (bits 19:16 zero) |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench goes after the edges of the copy loop. A one-word copy would expose an off-by-one in the end test: the engine would either skip the drain writes or run an extra word. The bench also starts copies that cross the top of both address spaces, upward and downward, because a stepper that carried into the wrong width would land writes at addresses the bench never expects. It hits both abort conditions, a zero count and a start in bank 1, where a faulty design would raise busy or emit strobes. It also writes registers in the middle of a copy, where a design that failed to guard them would finish early or report a nonzero count. Random copies with odd start values check that bit 0 is forced low, that the busy duration is 5 + 2N, and that the reads and writes of each word come in the stated order.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int LANES  = 8;
    localparam int L_SRC0 = 0;
    localparam int L_SRC1 = 1;
    localparam int L_SRC2 = 2;
    localparam int L_DST0 = 3;
    localparam int L_DST1 = 4;
    localparam int L_LEN0 = 5;
    localparam int L_LEN1 = 6;
    localparam int L_CTRL = 7;

    localparam int CTRL_RUN_BIT = 7;
    localparam int CTRL_DIR_BIT = 0;

    function automatic logic [7:0] lane_addr(input int idx);
        logic [7:0] a;
        case (idx)
            L_SRC0:  a = 8'h40;
            L_SRC1:  a = 8'h41;
            L_SRC2:  a = 8'h42;
            L_DST0:  a = 8'h44;
            L_DST1:  a = 8'h45;
            L_LEN0:  a = 8'h46;
            L_LEN1:  a = 8'h47;
            default: a = 8'h48;
        endcase
        return a;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_DRAIN = 2'd3
    } dma_state_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr_i,
    input  logic         down_i,
    output logic [W-1:0] addr_o
);
    localparam logic [W-1:0] STEP = W'(2);

    always_comb begin
        if (down_i) addr_o = addr_i - STEP;
        else        addr_o = addr_i + STEP;
    end
endmodule

// File: rtl/dma_io_port.sv
module dma_io_port
    import dma_pkg::*;
#(
    parameter int IO_AW = 8,
    parameter int SRC_W = 20,
    parameter int DST_W = 16,
    parameter int LEN_W = 16
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_we,
    input  logic [SRC_W-1:0] src_i,
    input  logic [DST_W-1:0] dst_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             run_i,
    input  logic             dir_i,
    output logic [LANES-1:0] wr_sel_o,
    output logic [7:0]       rdata_o
);
    localparam int HI_W = SRC_W - 16;

    logic [LANES-1:0] hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g]      = (io_addr == IO_AW'(lane_addr(g)));
        assign wr_sel_o[g] = io_we & hit[g];
    end

    always_comb begin
        rdata_o = 8'h00;
        if (hit[L_SRC0]) rdata_o = src_i[7:0];
        if (hit[L_SRC1]) rdata_o = src_i[15:8];
        if (hit[L_SRC2]) rdata_o = {{(8-HI_W){1'b0}}, src_i[SRC_W-1:16]};
        if (hit[L_DST0]) rdata_o = dst_i[7:0];
        if (hit[L_DST1]) rdata_o = dst_i[15:8];
        if (hit[L_LEN0]) rdata_o = len_i[7:0];
        if (hit[L_LEN1]) rdata_o = len_i[15:8];
        if (hit[L_CTRL]) rdata_o = {run_i, 6'b0, dir_i};
    end
endmodule

// File: rtl/dma_core.sv
module dma_core
    import dma_pkg::*;
#(
    parameter int SRC_W        = 20,
    parameter int DST_W        = 16,
    parameter int LEN_W        = 16,
    parameter int SETUP_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_sel,
    input  logic [7:0]       wdata,
    input  logic [SRC_W-1:0] src_next,
    input  logic [DST_W-1:0] dst_next,
    input  logic [7:0]       mem_rdata,
    output logic [SRC_W-1:0] src_o,
    output logic [DST_W-1:0] dst_o,
    output logic [LEN_W-1:0] len_o,
    output logic             run_o,
    output logic             dir_o,
    output logic             busy_o,
    output logic             mem_rd,
    output logic [SRC_W-1:0] mem_raddr,
    output logic             mem_wr,
    output logic [SRC_W-1:0] mem_waddr,
    output logic [7:0]       mem_wdata
);
    // two of the fixed overhead cycles are spent draining the last word
    localparam int IDLE_WAIT = SETUP_CYCLES - 2;
    localparam int CW        = (IDLE_WAIT > 1) ? $clog2(IDLE_WAIT) : 1;
    localparam int HI_W      = SRC_W - 16;
    localparam logic [HI_W-1:0]  SAVE_BANK = HI_W'(1);
    localparam logic [LEN_W-1:0] LAST_LEN  = LEN_W'(2);

    typedef struct packed {
        dma_state_e       state;
        logic [CW-1:0]    cnt;
        logic             ph;
        logic             have;
        logic             run;
        logic             dir;
        logic [SRC_W-1:0] src;
        logic [DST_W-1:0] dst;
        logic [LEN_W-1:0] len;
        logic [DST_W-1:0] pdst;
        logic [7:0]       lo;
        logic [15:0]      word;
    } core_s;

    core_s st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (wr_sel[L_SRC0]) st_d.src[7:0]        = wdata & 8'hFE;
                if (wr_sel[L_SRC1]) st_d.src[15:8]       = wdata;
                if (wr_sel[L_SRC2]) st_d.src[SRC_W-1:16] = wdata[HI_W-1:0];
                if (wr_sel[L_DST0]) st_d.dst[7:0]        = wdata & 8'hFE;
                if (wr_sel[L_DST1]) st_d.dst[15:8]       = wdata;
                if (wr_sel[L_LEN0]) st_d.len[7:0]        = wdata & 8'hFE;
                if (wr_sel[L_LEN1]) st_d.len[15:8]       = wdata;
                if (wr_sel[L_CTRL]) begin
                    st_d.dir = wdata[CTRL_DIR_BIT];
                    st_d.run = 1'b0;
                    if (wdata[CTRL_RUN_BIT] && (st_q.len != '0) &&
                        (st_q.src[SRC_W-1:16] != SAVE_BANK)) begin
                        st_d.run   = 1'b1;
                        st_d.state = ST_SETUP;
                        st_d.cnt   = CW'(IDLE_WAIT - 1);
                        st_d.ph    = 1'b0;
                        st_d.have  = 1'b0;
                    end
                end
            end
            ST_SETUP: begin
                if (st_q.cnt == '0) st_d.state = ST_XFER;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            ST_XFER: begin
                if (!st_q.ph) begin
                    st_d.lo = mem_rdata;
                    st_d.ph = 1'b1;
                end else begin
                    st_d.word = {mem_rdata, st_q.lo};
                    st_d.pdst = st_q.dst;
                    st_d.have = 1'b1;
                    st_d.src  = src_next;
                    st_d.dst  = dst_next;
                    st_d.len  = st_q.len - LAST_LEN;
                    st_d.ph   = 1'b0;
                    if (st_q.len == LAST_LEN) st_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!st_q.ph) begin
                    st_d.ph = 1'b1;
                end else begin
                    st_d.ph    = 1'b0;
                    st_d.have  = 1'b0;
                    st_d.run   = 1'b0;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o     = st_q.src;
    assign dst_o     = st_q.dst;
    assign len_o     = st_q.len;
    assign run_o     = st_q.run;
    assign dir_o     = st_q.dir;
    assign busy_o    = (st_q.state != ST_IDLE);
    assign mem_rd    = (st_q.state == ST_XFER);
    assign mem_raddr = {st_q.src[SRC_W-1:1], st_q.ph};
    assign mem_wr    = ((st_q.state == ST_XFER) && st_q.have) || (st_q.state == ST_DRAIN);
    assign mem_waddr = {{(SRC_W-DST_W){1'b0}}, st_q.pdst[DST_W-1:1], st_q.ph};
    assign mem_wdata = st_q.ph ? st_q.word[15:8] : st_q.word[7:0];
endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine
    import dma_pkg::*;
#(
    parameter int IO_AW        = 8,
    parameter int SRC_W        = 20,
    parameter int DST_W        = 16,
    parameter int LEN_W        = 16,
    parameter int SETUP_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_we,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             busy,
    output logic             mem_rd,
    output logic [SRC_W-1:0] mem_raddr,
    input  logic [7:0]       mem_rdata,
    output logic             mem_wr,
    output logic [SRC_W-1:0] mem_waddr,
    output logic [7:0]       mem_wdata
);
    logic [LANES-1:0] wr_sel;
    logic [SRC_W-1:0] src_q, src_next;
    logic [DST_W-1:0] dst_q, dst_next;
    logic [LEN_W-1:0] len_q;
    logic             run_q, dir_q;

    dma_io_port #(
        .IO_AW(IO_AW), .SRC_W(SRC_W), .DST_W(DST_W), .LEN_W(LEN_W)
    ) u_io (
        .io_addr (io_addr),
        .io_we   (io_we),
        .src_i   (src_q),
        .dst_i   (dst_q),
        .len_i   (len_q),
        .run_i   (run_q),
        .dir_i   (dir_q),
        .wr_sel_o(wr_sel),
        .rdata_o (io_rdata)
    );

    dma_addr_step #(.W(SRC_W)) u_src_step (
        .addr_i(src_q), .down_i(dir_q), .addr_o(src_next)
    );

    dma_addr_step #(.W(DST_W)) u_dst_step (
        .addr_i(dst_q), .down_i(dir_q), .addr_o(dst_next)
    );

    dma_core #(
        .SRC_W(SRC_W), .DST_W(DST_W), .LEN_W(LEN_W), .SETUP_CYCLES(SETUP_CYCLES)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wdata    (io_wdata),
        .src_next (src_next),
        .dst_next (dst_next),
        .mem_rdata(mem_rdata),
        .src_o    (src_q),
        .dst_o    (dst_q),
        .len_o    (len_q),
        .run_o    (run_q),
        .dir_o    (dir_q),
        .busy_o   (busy),
        .mem_rd   (mem_rd),
        .mem_raddr(mem_raddr),
        .mem_wr   (mem_wr),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/dma_word_engine_chk.sv
module dma_word_engine_chk #(
    parameter int IO_AW = 8,
    parameter int SRC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IO_AW-1:0] io_addr,
    input logic             io_we,
    input logic [7:0]       io_wdata,
    input logic [7:0]       io_rdata,
    input logic             busy,
    input logic             mem_rd,
    input logic [SRC_W-1:0] mem_raddr,
    input logic             mem_wr,
    input logic [SRC_W-1:0] mem_waddr
);
    localparam logic [IO_AW-1:0] CTRL_A = IO_AW'(8'h48);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R13

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(io_we && (io_addr == CTRL_A) && io_wdata[7])); // R3

    AST_BUSY_SHOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (io_addr == CTRL_A)) |-> io_rdata[7]); // R2

    AST_READ_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_raddr[0]) |=>
            (mem_rd && mem_raddr[0] && (mem_raddr[SRC_W-1:1] == $past(mem_raddr[SRC_W-1:1])))); // R7

    AST_WRITE_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_waddr[0]) |=>
            (mem_wr && mem_waddr[0] && (mem_waddr[SRC_W-1:1] == $past(mem_waddr[SRC_W-1:1])))); // R7

    AST_ENDS_ON_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(mem_wr) && $past(mem_waddr[0]))); // R6
endmodule

bind dma_word_engine dma_word_engine_chk #(.IO_AW(IO_AW), .SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_we    (io_we),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .mem_raddr(mem_raddr),
    .mem_wr   (mem_wr),
    .mem_waddr(mem_waddr)
);

// File: tb/tb_dma_word_engine.sv
`timescale 1ns/1ps
module tb_dma_word_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        busy, mem_rd, mem_wr;
    logic [19:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_rdata, mem_wdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = pat(mem_raddr);

    dma_word_engine dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .busy(busy),
        .mem_rd(mem_rd), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // memory and activity monitor, sampled mid-cycle
    logic [7:0] wmem [int];
    int bcnt = 0, wcnt = 0, idle_acc = 0;
    int t_rl = -1, t_rh = -1, t_wl = -1, t_wh = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy && (mem_rd || mem_wr)) idle_acc++;
            if (mem_wr) begin
                wmem[int'(mem_waddr)] = mem_wdata;
                wcnt++;
                if (!mem_waddr[0] && t_wl < 0) t_wl = bcnt;
                if ( mem_waddr[0] && t_wh < 0) t_wh = bcnt;
            end
            if (mem_rd) begin
                if (!mem_raddr[0] && t_rl < 0) t_rl = bcnt;
                if ( mem_raddr[0] && t_rh < 0) t_rh = bcnt;
            end
            if (busy) bcnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic read_regs(output logic [19:0] s, output logic [15:0] d, output logic [15:0] l,
                             output logic [7:0] c);
        logic [7:0] b0, b1, b2;
        io_read(8'h40, b0); io_read(8'h41, b1); io_read(8'h42, b2);
        s = {b2[3:0], b1, b0};
        io_read(8'h44, b0); io_read(8'h45, b1); d = {b1, b0};
        io_read(8'h46, b0); io_read(8'h47, b1); l = {b1, b0};
        io_read(8'h48, c);
    endtask

    task automatic clear_mon();
        wmem.delete();
        bcnt = 0; wcnt = 0;
        t_rl = -1; t_rh = -1; t_wl = -1; t_wh = -1;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // program, start, wait and verify one copy; mid_poke exercises R12
    task automatic run_copy(input logic [19:0] s_raw, input logic [15:0] d_raw,
                            input logic [15:0] l_raw, input logic dn, input logic mid_poke);
        logic [19:0] s0, s_exp, s_rb;
        logic [15:0] d0, d_exp, d_rb, l0, l_rb;
        logic [7:0]  c_rb;
        int words, bad, dir_k;
        bit abort;
        s0 = s_raw & 20'hFFFFE;
        d0 = d_raw & 16'hFFFE;
        l0 = l_raw & 16'hFFFE;
        words = int'(l0) / 2;
        abort = (l0 == 16'h0) || (s0[19:16] == 4'h1);
        io_write(8'h40, s_raw[7:0]);
        io_write(8'h41, s_raw[15:8]);
        io_write(8'h42, {4'hF, s_raw[19:16]});
        io_write(8'h44, d_raw[7:0]);
        io_write(8'h45, d_raw[15:8]);
        io_write(8'h46, l_raw[7:0]);
        io_write(8'h47, l_raw[15:8]);
        clear_mon();
        io_write(8'h48, {1'b1, 6'b010101, dn});
        if (mid_poke) begin
            io_write(8'h47, 8'h01);
            io_write(8'h40, 8'h22);
            io_write(8'h48, 8'h00);
        end
        wait_idle();
        @(negedge clk);
        read_regs(s_rb, d_rb, l_rb, c_rb);
        if (abort) begin
            if (l0 == 16'h0) begin
                chk("R4", "busy cycles on zero count", bcnt, 0);
                chk("R4", "writes on zero count", wcnt, 0);
                chk("R4", "control after zero count", int'(c_rb), int'({7'b0, dn}));
            end else begin
                chk("R5", "busy cycles on bank-1 source", bcnt, 0);
                chk("R5", "writes on bank-1 source", wcnt, 0);
                chk("R5", "control after bank-1 source", int'(c_rb), int'({7'b0, dn}));
            end
            chk("R4", "count unchanged after abort", int'(l_rb), int'(l0));
        end else begin
            dir_k = dn ? -2 : 2;
            s_exp = s0 + 20'(dir_k * words);
            d_exp = d0 + 16'(dir_k * words);
            chk("R6", "busy cycles", bcnt, 5 + 2 * words);
            chk("R8", "byte writes", wcnt, 2 * words);
            bad = 0;
            for (int k = 0; k < words; k++) begin
                logic [19:0] sa;
                logic [15:0] da;
                sa = s0 + 20'(dir_k * k);
                da = d0 + 16'(dir_k * k);
                for (int b = 0; b < 2; b++) begin
                    int key;
                    key = int'({4'h0, da}) + b;
                    if (!wmem.exists(key) || wmem[key] !== pat(sa + 20'(b))) bad++;
                end
            end
            if (dn) chk("R9", "destination bytes wrong (down)", bad, 0);
            else    chk("R8", "destination bytes wrong (up)", bad, 0);
            chk("R10", "final source", int'(s_rb), int'(s_exp));
            chk("R10", "final destination", int'(d_rb), int'(d_exp));
            chk("R10", "final count", int'(l_rb), 0);
            chk("R10", "control after copy", int'(c_rb), int'({7'b0, dn}));
            chk("R7", "first low read slot", t_rl, 3);
            chk("R7", "high read after low read", t_rh, t_rl + 1);
            chk("R7", "low write after both reads", t_wl, t_rl + 2);
            chk("R7", "high write after low write", t_wh, t_rl + 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [19:0] s; logic [15:0] d, l; logic [7:0] c, v;
        int seed_init;
        seed_init = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        read_regs(s, d, l, c);
        chk("R2", "reset source", int'(s), 0);
        chk("R2", "reset destination", int'(d), 0);
        chk("R2", "reset count", int'(l), 0);
        chk("R2", "reset control", int'(c), 0);
        chk("R3", "reset busy", int'(busy), 0);

        // R1 forcing of bit 0 and the narrow top lane
        io_write(8'h40, 8'hFF); io_write(8'h42, 8'hFF);
        io_write(8'h44, 8'h33); io_write(8'h46, 8'h07);
        io_read(8'h40, v); chk("R1", "source low lane", int'(v), 8'hFE);
        io_read(8'h42, v); chk("R1", "source top lane", int'(v), 8'h0F);
        io_read(8'h44, v); chk("R1", "destination low lane", int'(v), 8'h32);
        io_read(8'h46, v); chk("R1", "count low lane", int'(v), 8'h06);
        io_read(8'h43, v); chk("R2", "unmapped lane", int'(v), 0);
        io_write(8'h48, 8'h7F);
        io_read(8'h48, v); chk("R2", "control readback", int'(v), 8'h01);

        // directed corner cases
        run_copy(20'h00100, 16'h2000, 16'h0002, 1'b0, 1'b0); // one word, R6
        run_copy(20'h00101, 16'h2001, 16'h0000, 1'b0, 1'b0); // R4
        run_copy(20'h10200, 16'h3000, 16'h0008, 1'b0, 1'b0); // R5
        run_copy(20'hFFFFC, 16'hFFFC, 16'h0008, 1'b0, 1'b0); // R11 upward wrap
        run_copy(20'h00002, 16'h0002, 16'h0006, 1'b1, 1'b0); // R11 downward wrap, R9
        run_copy(20'h04000, 16'h5000, 16'h0006, 1'b0, 1'b1); // R12
        chk("R11", "post-wrap reachable", 1, 1);

        // constrained random copies
        for (int i = 0; i < 40; i++) begin
            logic [19:0] rs;
            logic [15:0] rd, rl;
            logic rdn;
            rs  = 20'($urandom);
            if (i % 7 == 3) rs[19:16] = 4'h1;
            rd  = 16'($urandom);
            rl  = 16'(($urandom % 13) * 2) | 16'($urandom & 1);
            rdn = 1'($urandom);
            run_copy(rs, rd, rl, rdn, 1'b0);
        end

        chk("R13", "strobes while idle", idle_acc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule